// File: doc/BRIEF.md
# Vector Length Set Unit

This block carries out one set-vector-length operation per strobe. It takes the current vector state word, a 7-bit immediate, three mode flags and two indications of whether the source and destination register fields are zero. It also takes the 64-bit source register value and the 64-bit loop count value. From these it works out a new maximum vector length (MVL) and a new vector length (VL).

VL is always held at or below MVL. Too-large sources saturate, and either kind of limiting raises an overflow flag. The block registers the updated state word, an optional destination register write carrying VL, and an optional 4-bit condition field.

Decoding, the register file and trap handling are outside the block. The surrounding pipeline presents the decoded fields and operands together with `op_valid`, and picks up the results one cycle later.

Top module: `vlen_set_unit`

## Requirements
- R1: When `set_max`=1, MVL becomes the low 7 bits of (`imm_field`+1), so immediate 0 gives 1 and immediate 127 gives 0.
- R2: When `set_max`=0, MVL keeps the value in `state_in[63:57]`.
- R3: When `set_len`=0, the VL candidate is the stored VL in `state_in[56:50]` (still subject to R6).
- R4: When `set_len`=1, the VL candidate comes from `src_value` if `src_is_zero`=0. It comes from the effective immediate of R1 if both zero flags are 1. It comes from `loop_count` if only `src_is_zero` is 1.
- R5: A register or loop-count source above 127 (unsigned) gives a candidate of 127 and raises overflow; otherwise the candidate is its low 7 bits.
- R6: If the candidate exceeds the new MVL, VL is set to MVL and overflow is raised. `state_out[56:50]` holds the final VL and `state_out[63:57]` holds MVL.
- R7: When `dst_is_zero`=0, `dst_wr` is 1 and `dst_data` is VL zero-extended to 64 bits. When it is 1, `dst_wr` is 0.
- R8: When `set_max`=1, `state_out[0]` (vertical-first) takes `vert_first` and `state_out[1]` (persistence) is cleared. When `set_max`=0, both bits keep their `state_in` values.
- R9: When `want_cond`=1, `cond_wr`=1 and `cond` has the following bits:
  - bit 3 (LT) is 0;
  - bit 2 (GT) is set when VL is nonzero;
  - bit 1 (EQ) is set when VL is zero;
  - bit 0 (SO) carries overflow, whatever `dst_is_zero` is.

  When `want_cond`=0, `cond_wr`=0 and `cond`=0.
- R10: `state_out[49:2]` equals `state_in[49:2]`. All results appear with `res_valid` exactly one cycle after `op_valid`, and `res_valid` is low in a cycle that follows no strobe.
- R11: After reset, `res_valid`, `state_out`, `dst_wr`, `dst_data`, `cond_wr` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| imm_field | input | 7 | Immediate length minus one |
| set_max | input | 1 | Write MVL from the immediate |
| set_len | input | 1 | Write VL from a source |
| vert_first | input | 1 | Vertical-first value used with set_max |
| want_cond | input | 1 | Produce a condition field |
| src_is_zero | input | 1 | Source register field is zero |
| dst_is_zero | input | 1 | Destination register field is zero |
| src_value | input | 64 | Source register contents |
| loop_count | input | 64 | Loop count register contents |
| state_in | input | 64 | Current vector state word |
| res_valid | output | 1 | Results valid |
| state_out | output | 64 | Updated vector state word |
| dst_wr | output | 1 | Destination register write enable |
| dst_data | output | 64 | Destination register data |
| cond_wr | output | 1 | Condition field write enable |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The hardest case is an overflow from a source that is not obviously too large. One form is a stored VL above the stored MVL, which shows up only with `set_len`=0. The other is a loop count whose only set bits lie above bit 31, so its low 7 bits look harmless. Directed vectors build such state words and operands on purpose. They also cover the limits of 127 against 128 and the immediate that wraps to zero, so that saturation and the MVL clamp are each seen alone and together.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [1:0] {
        LSRC_KEEP  = 2'd0,
        LSRC_IMM   = 2'd1,
        LSRC_REG   = 2'd2,
        LSRC_COUNT = 2'd3
    } len_src_e;

    localparam int COND_W   = 4;
    localparam int COND_LT  = 3;
    localparam int COND_GT  = 2;
    localparam int COND_EQ  = 1;
    localparam int COND_SO  = 0;

    localparam int PST_BIT  = 1;
    localparam int VF_BIT   = 0;

endpackage

// File: rtl/vls_saturate.sv
module vls_saturate #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 7
) (
    input  logic [IN_W-1:0]  value,
    output logic [OUT_W-1:0] result,
    output logic             sat
);
    localparam int HIGH_W = IN_W - OUT_W;

    generate
        if (HIGH_W > 0) begin : g_wide
            always_comb begin
                sat    = |value[IN_W-1:OUT_W];
                result = sat ? {OUT_W{1'b1}} : value[OUT_W-1:0];
            end
        end else begin : g_narrow
            always_comb begin
                sat    = 1'b0;
                result = value[OUT_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/vls_len_select.sv
module vls_len_select
    import vls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic             set_len,
    input  logic             src_is_zero,
    input  logic             dst_is_zero,
    input  logic [LEN_W-1:0] imm_len,
    input  logic [LEN_W-1:0] stored_len,
    input  logic [XLEN-1:0]  src_value,
    input  logic [XLEN-1:0]  loop_count,
    output logic [LEN_W-1:0] cand_len,
    output logic             sat_ovf,
    output len_src_e         src_sel
);
    localparam int NSRC = 2;

    logic [XLEN-1:0]  raw_val [NSRC];
    logic [LEN_W-1:0] sat_val [NSRC];
    logic [NSRC-1:0]  sat_hit;

    assign raw_val[0] = src_value;
    assign raw_val[1] = loop_count;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_sat
            vls_saturate #(
                .IN_W  (XLEN),
                .OUT_W (LEN_W)
            ) u_sat (
                .value  (raw_val[g]),
                .result (sat_val[g]),
                .sat    (sat_hit[g])
            );
        end
    endgenerate

    always_comb begin
        if (!set_len)          src_sel = LSRC_KEEP;
        else if (!src_is_zero) src_sel = LSRC_REG;
        else if (dst_is_zero)  src_sel = LSRC_IMM;
        else                   src_sel = LSRC_COUNT;
    end

    always_comb begin
        cand_len = stored_len;
        sat_ovf  = 1'b0;
        unique case (src_sel)
            LSRC_KEEP:  cand_len = stored_len;
            LSRC_IMM:   cand_len = imm_len;
            LSRC_REG: begin
                cand_len = sat_val[0];
                sat_ovf  = sat_hit[0];
            end
            LSRC_COUNT: begin
                cand_len = sat_val[1];
                sat_ovf  = sat_hit[1];
            end
            default:    cand_len = stored_len;
        endcase
    end

    // R5: a saturated source always presents the largest length
    always_comb begin
        if (sat_ovf) assert_sat_is_max_R5: assert (&cand_len);
    end

endmodule

// File: rtl/vls_clamp.sv
module vls_clamp #(
    parameter int LEN_W = 7
) (
    input  logic [LEN_W-1:0] cand_len,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] final_len,
    output logic             clipped
);
    always_comb begin
        clipped   = cand_len > limit;
        final_len = clipped ? limit : cand_len;
    end

endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
    import vls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [LEN_W-1:0]  imm_field,
    input  logic              set_max,
    input  logic              set_len,
    input  logic              vert_first,
    input  logic              want_cond,
    input  logic              src_is_zero,
    input  logic              dst_is_zero,
    input  logic [XLEN-1:0]   src_value,
    input  logic [XLEN-1:0]   loop_count,
    input  logic [XLEN-1:0]   state_in,
    output logic              res_valid,
    output logic [XLEN-1:0]   state_out,
    output logic              dst_wr,
    output logic [XLEN-1:0]   dst_data,
    output logic              cond_wr,
    output logic [COND_W-1:0] cond
);
    localparam int MVL_LSB = XLEN - LEN_W;
    localparam int VL_LSB  = XLEN - 2 * LEN_W;
    localparam int MID_HI  = VL_LSB - 1;
    localparam int MID_LO  = PST_BIT + 1;

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   state;
        logic              dwr;
        logic [XLEN-1:0]   ddata;
        logic              cwr;
        logic [COND_W-1:0] cfield;
    } result_t;

    result_t res_d, res_q;

    logic [LEN_W-1:0] imm_eff;
    logic [LEN_W-1:0] mvl_new;
    logic [LEN_W-1:0] cand_len;
    logic [LEN_W-1:0] vl_new;
    logic             sat_ovf;
    logic             clip_ovf;
    logic             ovf;
    len_src_e         src_sel;

    always_comb begin
        imm_eff = imm_field + LEN_W'(1);
        mvl_new = set_max ? imm_eff : state_in[MVL_LSB +: LEN_W];
    end

    vls_len_select #(
        .XLEN  (XLEN),
        .LEN_W (LEN_W)
    ) u_sel (
        .set_len     (set_len),
        .src_is_zero (src_is_zero),
        .dst_is_zero (dst_is_zero),
        .imm_len     (imm_eff),
        .stored_len  (state_in[VL_LSB +: LEN_W]),
        .src_value   (src_value),
        .loop_count  (loop_count),
        .cand_len    (cand_len),
        .sat_ovf     (sat_ovf),
        .src_sel     (src_sel)
    );

    vls_clamp #(
        .LEN_W (LEN_W)
    ) u_clamp (
        .cand_len  (cand_len),
        .limit     (mvl_new),
        .final_len (vl_new),
        .clipped   (clip_ovf)
    );

    assign ovf = sat_ovf | clip_ovf;

    always_comb begin
        res_d       = '0;
        res_d.valid = op_valid;
        if (op_valid) begin
            res_d.state                      = state_in;
            res_d.state[MVL_LSB +: LEN_W]    = mvl_new;
            res_d.state[VL_LSB +: LEN_W]     = vl_new;
            if (set_max) begin
                res_d.state[VF_BIT]  = vert_first;
                res_d.state[PST_BIT] = 1'b0;
            end
            res_d.dwr   = !dst_is_zero;
            res_d.ddata = dst_is_zero ? '0 : XLEN'(vl_new);
            res_d.cwr   = want_cond;
            if (want_cond) begin
                res_d.cfield[COND_LT] = 1'b0;
                res_d.cfield[COND_GT] = |vl_new;
                res_d.cfield[COND_EQ] = ~|vl_new;
                res_d.cfield[COND_SO] = ovf;
            end
        end else begin
            res_d.state = res_q.state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign state_out = res_q.state;
    assign dst_wr    = res_q.dwr;
    assign dst_data  = res_q.ddata;
    assign cond_wr   = res_q.cwr;
    assign cond      = res_q.cfield;

    // R4: a register source needs a nonzero source field
    assert_reg_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == LSRC_REG) |-> (set_len && !src_is_zero));

    // R6: a committed length never exceeds the committed maximum
    assert_vl_within_mvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (state_out[VL_LSB +: LEN_W] <= state_out[MVL_LSB +: LEN_W]));

    assert_dst_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |-> (dst_data == XLEN'(state_out[VL_LSB +: LEN_W])));

    assert_cond_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cond_wr |-> ($countones(cond[COND_GT:COND_EQ]) == 1 && !cond[COND_LT]));

    assert_cond_matches_vl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cond_wr |-> (cond[COND_EQ] == (state_out[VL_LSB +: LEN_W] == '0)));

    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (state_out[MID_HI:MID_LO] == $past(state_in[MID_HI:MID_LO])));

    assert_mode_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !set_max) |=> (state_out[PST_BIT:VF_BIT] == $past(state_in[PST_BIT:VF_BIT])));

    assert_mvl_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !set_max) |=> (state_out[MVL_LSB +: LEN_W] == $past(state_in[MVL_LSB +: LEN_W])));

endmodule

// File: tb/tb_vlen_set_unit.sv
module tb_vlen_set_unit;

    typedef struct packed {
        logic        ms, vs, vf, rc, sz, dz;
        logic [6:0]  imm;
        logic [63:0] srcv;
        logic [63:0] cnt;
        logic [6:0]  smvl, svl;
        logic [6:0]  emvl, evl;
        logic        eovf;
    } vec_t;

    localparam int NV = 16;
    localparam logic [47:0] MID = 48'hA5C3_0F96_3C5A;

    // fields: ms vs vf rc sz dz imm src cnt smvl svl | emvl evl eovf
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,7'd7,  64'd0,   64'd0,   7'd3,  7'd3,  7'd8,  7'd8,  1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,7'd127,64'd0,   64'd0,   7'd5,  7'd5,  7'd0,  7'd0,  1'b0},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,7'd0,  64'd20,  64'd999, 7'd32, 7'd1,  7'd32, 7'd20, 1'b0},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,7'd0,  64'd200, 64'd3,   7'd127,7'd0,  7'd127,7'd127,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,7'd0,  64'd50,  64'd0,   7'd16, 7'd0,  7'd16, 7'd16, 1'b1},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,7'd0,  64'd77,  64'd9,   7'd64, 7'd0,  7'd64, 7'd9,  1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'd0,  64'd0,   64'h1_0000_0005, 7'd100,7'd0,7'd100,7'd100,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,7'd0,  64'd55,  64'd55,  7'd20, 7'd10, 7'd20, 7'd10, 1'b0},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,7'd0,  64'd0,   64'd0,   7'd20, 7'd30, 7'd20, 7'd20, 1'b1},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,7'd3,  64'd0,   64'd0,   7'd90, 7'd2,  7'd4,  7'd2,  1'b0},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,7'd3,  64'd0,   64'd0,   7'd90, 7'd9,  7'd4,  7'd4,  1'b1},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,7'd0,  64'd128, 64'd0,   7'd127,7'd0,  7'd127,7'd127,1'b1},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,7'd0,  64'd127, 64'd0,   7'd127,7'd0,  7'd127,7'd127,1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,7'd5,  64'd0,   64'd0,   7'd1,  7'd1,  7'd6,  7'd0,  1'b0},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,7'd9,  64'd0,   64'd500, 7'd60, 7'd0,  7'd60, 7'd10, 1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,7'd0,  64'd0,   64'd0,   7'd0,  7'd0,  7'd1,  7'd1,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [6:0]  imm_field = '0;
    logic        set_max = 1'b0, set_len = 1'b0, vert_first = 1'b0, want_cond = 1'b0;
    logic        src_is_zero = 1'b1, dst_is_zero = 1'b1;
    logic [63:0] src_value = '0, loop_count = '0, state_in = '0;
    logic        res_valid, dst_wr, cond_wr;
    logic [63:0] state_out, dst_data;
    logic [3:0]  cond;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vlen_set_unit dut (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .imm_field (imm_field),
        .set_max (set_max), .set_len (set_len), .vert_first (vert_first),
        .want_cond (want_cond), .src_is_zero (src_is_zero), .dst_is_zero (dst_is_zero),
        .src_value (src_value), .loop_count (loop_count), .state_in (state_in),
        .res_valid (res_valid), .state_out (state_out), .dst_wr (dst_wr),
        .dst_data (dst_data), .cond_wr (cond_wr), .cond (cond)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic [1:0] low);
        logic [63:0] exp_state;
        logic [3:0]  exp_cond;
        @(negedge clk);
        set_max = v.ms; set_len = v.vs; vert_first = v.vf; want_cond = v.rc;
        src_is_zero = v.sz; dst_is_zero = v.dz; imm_field = v.imm;
        src_value = v.srcv; loop_count = v.cnt;
        state_in = {v.smvl, v.svl, MID, low};
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        exp_state = {v.emvl, v.evl, MID, (v.ms ? {1'b0, v.vf} : low)};
        exp_cond  = v.rc ? {1'b0, v.evl != 7'd0, v.evl == 7'd0, v.eovf} : 4'b0000;
        check("R10 res_valid", {63'd0, res_valid}, 64'd1);
        check("R1/R2/R3/R4/R5/R6/R8/R10 state", state_out, exp_state);
        check("R7 dst_wr", {63'd0, dst_wr}, {63'd0, !v.dz});
        if (!v.dz) check("R7 dst_data", dst_data, {57'd0, v.evl});
        check("R9 cond_wr", {63'd0, cond_wr}, {63'd0, v.rc});
        check("R9 cond", {60'd0, cond}, {60'd0, exp_cond});
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11 res_valid", {63'd0, res_valid}, 64'd0);
        check("R11 state_out", state_out, 64'd0);
        check("R11 dst_wr", {63'd0, dst_wr}, 64'd0);
        check("R11 dst_data", dst_data, 64'd0);
        check("R11 cond", {59'd0, cond_wr, cond}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle res_valid", {63'd0, res_valid}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 2'b10);

        // R10: no strobe, no result
        @(negedge clk);
        check("R10 idle after op", {63'd0, res_valid}, 64'd0);

        // R8: ms=0 keeps both mode bits as given, vf input ignored
        run_vec('{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,7'd2,64'd0,64'd0,7'd10,7'd0,7'd10,7'd3,1'b0}, 2'b01);
        run_vec('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,7'd0,64'd0,64'd0,7'd10,7'd4,7'd10,7'd4,1'b0}, 2'b11);
        // R8: ms=1 clears persistence and writes vf=0
        run_vec('{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,7'd9,64'd0,64'd0,7'd10,7'd4,7'd10,7'd4,1'b0}, 2'b11);
        // R5/R6: high-half loop count saturates, MVL small
        run_vec('{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,7'd0,64'd0,64'h8000_0000_0000_0000,7'd5,7'd0,7'd5,7'd5,1'b1}, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule